// File: doc/BRIEF.md
# Odd-Value Cycle Counter

This block is a 3-bit synchronous counter that visits only the odd values 1, 3, 5 and 7 and then starts over at 1. Each bit of the count sits in its own JK flip-flop. A small combinational stage works out the J and K inputs of all three flip-flops from the present count. The J/K values come from the JK excitation rules, so the count moves to the next odd value on each rising clock edge. A flip-flop whose present and next values agree gets a hold input. One whose value must change gets a set, reset or complement input.

The even values 0, 2, 4 and 6 lie outside the cycle. If the count ever holds one of them, the next edge moves it to 7, and from there it carries on 1, 3, 5. Each flip-flop also has its own asynchronous active-low preset and clear. These are used to start the counter, normally at 1, or to place it in any chosen state. A flip-flop clocks only while both of its controls are high.

Top module: `odd_seq_counter`

## Requirements
- R1: With every preset and clear high, each rising clock edge moves the count, read as {bit2, bit1, bit0} with bit0 least significant, from 1 to 3, 3 to 5, 5 to 7 and 7 back to 1.
- R2: With every preset and clear high, a count of 0, 2, 4 or 6 becomes 7 on the next rising edge.
- R3: With every preset and clear high, bit0 of the count is 1 after every rising edge, whatever the count was before the edge.
- R4: Pulling a bit's clear input low drives that bit to 0 at once, with no clock edge needed.
- R5: Pulling a bit's preset input low drives that bit to 1 at once, with no clock edge needed.
- R6: A flip-flop whose preset or clear is low ignores clock edges. The other flip-flops keep clocking from their own J and K inputs.
- R7: If preset and clear of one bit are both low, which is an illegal input, clear wins and the bit reads 0. A simulation message reports the clash.
- R8: After a recovery from an even state, the count follows 7, 1, 3, 5, 7 without any further intervention.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the flip-flops update on its rising edge |
| set_n | input | 3 | Per-bit asynchronous preset, active low, forces the bit to 1 |
| clr_n | input | 3 | Per-bit asynchronous clear, active low, forces the bit to 0; wins over preset |
| count | output | 3 | Present count {bit2, bit1, bit0} |

## Verification
The clocked next-state checks assume that no asynchronous control changes part-way through a clock period in a way that would cut into a transition they are tracking. They are switched off in any cycle in which a preset or clear is sampled low. The stimulus respects this. Controls are changed only just after a falling edge, and each forced state is held across one full rising edge before release, so every forcing episode is plainly visible to the disable condition. The illegal case of preset and clear both low on one bit is driven on purpose only once, to check clear priority. It is reported by message rather than by a failing assertion.

// File: rtl/odd_ctr_pkg.sv
package odd_ctr_pkg;

  localparam int CNT_W = 3;
  localparam int TOP_VAL = (1 << CNT_W) - 1;

  typedef logic [CNT_W-1:0] cnt_t;

  // Characteristic behaviour of one JK stage: hold, reset, set, complement.
  function automatic logic jk_step(input logic q, input logic j, input logic k);
    logic r;
    case ({j, k})
      2'b00:   r = q;
      2'b01:   r = 1'b0;
      2'b10:   r = 1'b1;
      default: r = ~q;
    endcase
    return r;
  endfunction

  // Intended successor of a count, written as a plain rule for the checks.
  function automatic cnt_t odd_successor(input cnt_t c);
    cnt_t r;
    if (!c[0])                  r = cnt_t'(TOP_VAL);
    else if (c == cnt_t'(TOP_VAL)) r = cnt_t'(1);
    else                        r = c + cnt_t'(2);
    return r;
  endfunction

endpackage

// File: rtl/odd_jk_cell.sv
module odd_jk_cell (
  input  logic clk,
  input  logic set_n,
  input  logic clr_n,
  input  logic j,
  input  logic k,
  output logic q
);
  import odd_ctr_pkg::*;

  logic ctl_low;
  assign ctl_low = !set_n || !clr_n;

  always_ff @(posedge clk or negedge set_n or negedge clr_n) begin
    if (!clr_n)      q <= 1'b0;
    else if (!set_n) q <= 1'b1;
    else             q <= jk_step(q, j, k);
  end

  // Illegal control combination is reported, clear keeps priority.
  always @(set_n, clr_n) begin
    if (set_n === 1'b0 && clr_n === 1'b0)
      $display("%0t odd_jk_cell %m: preset and clear low together, clear wins", $time);
  end

  AST_CLR_FORCES_ZERO: assert property (@(posedge clk) disable iff (set_n !== 1'b1)
    !clr_n |-> !q); // R4
  AST_SET_FORCES_ONE: assert property (@(posedge clk) disable iff (clr_n !== 1'b1)
    !set_n |-> q); // R5
  AST_JK_HOLD: assert property (@(posedge clk) disable iff (ctl_low)
    (!j && !k) |=> q == $past(q)); // R6
  AST_JK_COMPLEMENT: assert property (@(posedge clk) disable iff (ctl_low)
    (j && k) |=> q != $past(q)); // R1

endmodule

// File: rtl/odd_exc_logic.sv
module odd_exc_logic
  import odd_ctr_pkg::*;
(
  input  cnt_t q,
  output cnt_t j,
  output cnt_t k
);
  // Minimised J/K equations from the excitation rules with the
  // don't-care entries chosen to keep each term short.
  // bit0: always next 1          -> set
  // bit1: 0 always rises; 1 falls only when bit0 is 1
  // bit2: 0 rises unless count is 1; 1 falls only at 7
  assign j[0] = 1'b1;
  assign k[0] = 1'b0;
  assign j[1] = 1'b1;
  assign k[1] = q[0];
  assign j[2] = q[1] | ~q[0];
  assign k[2] = q[1] & q[0];

endmodule

// File: rtl/odd_seq_counter.sv
module odd_seq_counter
  import odd_ctr_pkg::*;
(
  input  logic             clk,
  input  logic [CNT_W-1:0] set_n,
  input  logic [CNT_W-1:0] clr_n,
  output logic [CNT_W-1:0] count
);

  cnt_t j_vec;
  cnt_t k_vec;
  cnt_t q_vec;
  logic init_active;

  assign init_active = !(&set_n) || !(&clr_n);

  odd_exc_logic u_exc (
    .q (q_vec),
    .j (j_vec),
    .k (k_vec)
  );

  for (genvar b = 0; b < CNT_W; b++) begin : g_bit
    odd_jk_cell u_cell (
      .clk   (clk),
      .set_n (set_n[b]),
      .clr_n (clr_n[b]),
      .j     (j_vec[b]),
      .k     (k_vec[b]),
      .q     (q_vec[b])
    );
  end

  assign count = q_vec;

  AST_ODD_STEP: assert property (@(posedge clk) disable iff (init_active)
    $past(count[0]) |=> count == odd_successor($past(count))); // R1
  AST_EVEN_RECOVER: assert property (@(posedge clk) disable iff (init_active)
    !count[0] |=> count == cnt_t'(TOP_VAL)); // R2
  AST_LSB_SET: assert property (@(posedge clk) disable iff (init_active)
    1'b1 |=> count[0]); // R3
  AST_REJOIN: assert property (@(posedge clk) disable iff (init_active)
    (count == cnt_t'(TOP_VAL)) |=> count == cnt_t'(1)); // R8

endmodule

// File: tb/odd_seq_counter_tb.sv
module odd_seq_counter_tb_top;

  logic       clk = 1'b0;
  logic [2:0] set_n;
  logic [2:0] clr_n;
  logic [2:0] count;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  odd_seq_counter dut_i (
    .clk   (clk),
    .set_n (set_n),
    .clr_n (clr_n),
    .count (count)
  );

  // Stimulus table: forced state and expected state one edge later.
  localparam logic [2:0] VEC_START [8] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
  localparam logic [2:0] VEC_NEXT  [8] = '{3'd7, 3'd3, 3'd7, 3'd5, 3'd7, 3'd7, 3'd7, 3'd1};

  function automatic logic [2:0] model_next(input logic [2:0] s);
    return (s % 2 == 0) ? 3'd7 : ((s == 3'd7) ? 3'd1 : 3'(s + 2));
  endfunction

  task automatic check(input string req, input logic [2:0] exp_v);
    total++;
    if (count !== exp_v) begin
      bad++;
      $display("FAIL %s: count=%0d expected=%0d at %0t", req, count, exp_v, $time);
    end
  endtask

  // Force state s through the asynchronous controls across one rising edge.
  task automatic force_state(input logic [2:0] s, input string req);
    @(negedge clk);
    #1;
    set_n = ~s;
    clr_n = s;
    #1;
    check(req, s);
    @(negedge clk);
    #1;
    set_n = 3'b111;
    clr_n = 3'b111;
  endtask

  task automatic step_and_check(input string req, input logic [2:0] exp_v);
    @(posedge clk);
    #2;
    check(req, exp_v);
  endtask

  initial begin
    set_n = 3'b111;
    clr_n = 3'b000;
    #1;
    check("R4 reset state", 3'd0);

    // Table walk: every state forced, one edge, compare to table and model.
    for (int i = 0; i < 8; i++) begin
      force_state(VEC_START[i], "R4/R5 forced load");
      step_and_check(VEC_START[i][0] ? "R1 odd step" : "R2 even recovery", VEC_NEXT[i]);
      total++;
      if (VEC_NEXT[i] !== model_next(VEC_START[i])) begin
        bad++;
        $display("FAIL R1 table: entry=%0d expected=%0d", VEC_NEXT[i], model_next(VEC_START[i]));
      end
      total++;
      if (count[0] !== 1'b1) begin
        bad++;
        $display("FAIL R3 lsb: count=%0d expected odd", count);
      end
    end

    // Two full cycles from 1.
    force_state(3'd1, "R5 init to 1");
    begin
      logic [2:0] e;
      e = 3'd1;
      for (int n = 0; n < 8; n++) begin
        e = model_next(e);
        step_and_check("R1 two cycles", e);
      end
    end

    // Each unused state recovers to 7 then rejoins 1, 3, 5, 7.
    for (int s = 0; s < 8; s += 2) begin
      force_state(3'(s), "R4 force even");
      step_and_check("R2 even to 7", 3'd7);
      step_and_check("R8 rejoin 1", 3'd1);
      step_and_check("R8 rejoin 3", 3'd3);
      step_and_check("R8 rejoin 5", 3'd5);
      step_and_check("R8 rejoin 7", 3'd7);
    end

    // R6: bit2 held in clear while others clock from 0.
    @(negedge clk);
    #1;
    clr_n = 3'b000;
    #1;
    check("R4 all clear", 3'd0);
    @(negedge clk);
    #1;
    clr_n = 3'b011;
    step_and_check("R6 held bit ignores clock", 3'b011);
    step_and_check("R6 held bit ignores clock again", 3'b001);
    @(negedge clk);
    #1;
    clr_n = 3'b111;

    // R7: preset and clear both low on bit1 while presetting all.
    @(negedge clk);
    #1;
    set_n = 3'b000;
    clr_n = 3'b101;
    #1;
    check("R7 clear wins", 3'b101);
    @(negedge clk);
    #1;
    set_n = 3'b111;
    clr_n = 3'b111;
    step_and_check("R1 after clash 5 to 7", 3'd7);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule